// File: doc/BRIEF.md
# Echo-Driven D-Channel Access Arbiter

This block sits on the terminal side of a shared ISDN D channel and decides when its terminal may send. Several terminals drive the same D bits toward the network. The network reflects the combined line state back as an echo bit, and because the bus behaves as a wired AND, any zero on it wins. The arbiter counts consecutive echo ones to decide that the line is quiet. It then shifts the terminal's D bits out one per bit strobe. It compares every echo with the bit it sent, and it withdraws as soon as a sent one returns as a zero.

The quiet-run length the arbiter demands comes from a two-class priority scheme. Each class has a normal and a lowered threshold. The lowered threshold is one step longer, and it applies to the first wait after a message has been sent successfully. This keeps access fair among the terminals. An external HDLC controller supplies the bits through a one-clock acknowledge handshake. It reads the access state from a dedicated output or from bit 5 of a status byte.

There are two named states. In WAIT the arbiter holds the line at one and counts idle echo ones. In SEND it drives the captured bit. The transitions are as follows. WAIT to SEND happens on a strobe with a request and a complete idle run. SEND to SEND happens on a strobe whose echo matches the sent bit when more bits follow. SEND to WAIT happens on a collision strobe, or on the strobe that confirms the final bit.

Top module: `dchan_access_arbiter`

## Requirements
- R1: While rst_n is low and on the first cycle after it is released, d_out is 1, access_granted is 0, tx_bit_ack, collision and tx_done are 0, the priority is at its normal level and the idle run count is zero (monitor_status reads 0x00 with prio_class 0).
- R2: In WAIT, a strobe with echo_in 1 raises the idle run count by one. A strobe with echo_in 0 clears the count to zero. The count saturates once it reaches the current threshold, so an idle line of any length keeps it reported as reached.
- R3: The threshold is 8 (normal) or 9 (lowered) for prio_class 0, and 10 or 11 for prio_class 1. WAIT moves to SEND on the first strobe with tx_req 1 at which the count already stands at or above the threshold.
- R4: In WAIT, d_out stays 1 and tx_req has no effect until the threshold is reached.
- R5: On the strobe that grants access, and on each SEND strobe that continues a message, the block captures tx_bit_in and tx_last. tx_bit_ack pulses for exactly one clock, and d_out carries the captured bit from the following clock until the next strobe.
- R6: In SEND, a strobe whose echo equals the sent bit (including a sent 0 echoed as 0) keeps access.
- R7: In SEND, a strobe with a sent 1 and echo_in 0 pulses collision for one clock. The block drops access_granted, returns d_out to 1 and re-enters WAIT with the run count at zero and the priority level unchanged, so that a fresh full run is needed.
- R8: A SEND strobe that confirms the final bit (tx_last captured, with no collision) pulses tx_done for one clock, returns to WAIT and switches the priority to its lowered level.
- R9: The lowered level returns to normal on the first WAIT strobe at which the count has already reached the lowered threshold.
- R10: monitor_status holds access_granted at bit 5, the threshold-reached flag at bit 4, the lowered-level flag at bit 3 and prio_class at bit 2. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_strobe | input | 1 | One-clock pulse per D-bit period |
| echo_in | input | 1 | Echo bit returned for the current period |
| tx_req | input | 1 | Controller has a message to send |
| tx_bit_in | input | 1 | Next D bit of the message |
| tx_last | input | 1 | tx_bit_in is the final bit |
| prio_class | input | 1 | Priority class: 0 (thresholds 8/9) or 1 (10/11) |
| d_out | output | 1 | D bit driven to the line, 1 when idle |
| tx_bit_ack | output | 1 | One-clock pulse: tx_bit_in was taken |
| access_granted | output | 1 | High in SEND |
| collision | output | 1 | One-clock pulse on a lost collision |
| tx_done | output | 1 | One-clock pulse on a completed message |
| monitor_status | output | 8 | Status byte, access state at bit 5 |

## Verification
A run counter that does not clear, or one that wraps instead of saturating, shows up as a grant that comes a strobe too early, or as a grant that never comes after a long idle line. The error appears within one threshold's worth of strobes. A priority level that does not lower, or does not restore, moves the grant strobe by exactly one position in the wait that follows, and monitor bit 3 shows the level directly. A state machine that ignores a collision keeps d_out at zero or access_granted high on the clock after the losing strobe, so the error appears at once.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    // priority scheme
    localparam int unsigned BASE_RUN    = 8;
    localparam int unsigned CLASS_STEP  = 2;
    localparam int unsigned LOWER_STEP  = 1;
    localparam int unsigned NUM_CLASSES = 2;

    localparam int unsigned MAX_RUN = BASE_RUN + (NUM_CLASSES - 1) * CLASS_STEP + LOWER_STEP;
    localparam int unsigned RUN_W   = $clog2(MAX_RUN + 1);
    localparam int unsigned CLASS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1;

    // status byte layout
    localparam int unsigned MON_GRANT_BIT = 5;
    localparam int unsigned MON_READY_BIT = 4;
    localparam int unsigned MON_LOWER_BIT = 3;
    localparam int unsigned MON_CLASS_BIT = 2;

    typedef enum logic {
        ACC_WAIT = 1'b0,
        ACC_SEND = 1'b1
    } acc_state_e;

endpackage

// File: rtl/dacc_run_counter.sv
module dacc_run_counter #(
    parameter int unsigned RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             echo,
    input  logic             clear,
    input  logic [RUN_W-1:0] thr,
    output logic [RUN_W-1:0] run_cnt,
    output logic             ready
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clear) begin
            run_cnt <= '0;
        end else if (strobe) begin
            if (!echo) begin
                run_cnt <= '0;
            end else if (run_cnt < thr) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign ready = (run_cnt >= thr);

endmodule

// File: rtl/dacc_prio_tracker.sv
module dacc_prio_tracker #(
    parameter int unsigned BASE_RUN    = 8,
    parameter int unsigned CLASS_STEP  = 2,
    parameter int unsigned LOWER_STEP  = 1,
    parameter int unsigned NUM_CLASSES = 2,
    parameter int unsigned CLASS_W     = 1,
    parameter int unsigned RUN_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CLASS_W-1:0] prio_class,
    input  logic               lower_evt,
    input  logic               restore_evt,
    output logic [RUN_W-1:0]   thr,
    output logic               lowered
);

    logic [RUN_W-1:0] norm_thr [NUM_CLASSES];
    logic [CLASS_W-1:0] cls_idx;

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_thr
        assign norm_thr[g] = RUN_W'(BASE_RUN + g * CLASS_STEP);
    end

    always_comb begin
        if (int'(prio_class) < NUM_CLASSES) begin
            cls_idx = prio_class;
        end else begin
            cls_idx = CLASS_W'(NUM_CLASSES - 1);
        end
    end

    assign thr = norm_thr[cls_idx] + (lowered ? RUN_W'(LOWER_STEP) : RUN_W'(0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowered <= 1'b0;
        end else if (lower_evt) begin
            lowered <= 1'b1;
        end else if (restore_evt && lowered) begin
            lowered <= 1'b0;
        end
    end

endmodule

// File: rtl/dacc_tx_fsm.sv
module dacc_tx_fsm
    import dacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       echo,
    input  logic       tx_req,
    input  logic       tx_bit_in,
    input  logic       tx_last,
    input  logic       ready,
    output acc_state_e state,
    output logic       start_tx,
    output logic       done_evt,
    output logic       d_out,
    output logic       tx_bit_ack,
    output logic       collision,
    output logic       tx_done
);

    acc_state_e state_nx;
    logic       cur_bit;
    logic       cur_last;
    logic       lost;

    assign lost     = cur_bit & ~echo;
    assign start_tx = (state == ACC_WAIT) && strobe && tx_req && ready;
    assign done_evt = (state == ACC_SEND) && strobe && !lost && cur_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ACC_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ACC_WAIT: begin
                if (start_tx) begin
                    state_nx = ACC_SEND;
                end
            end
            ACC_SEND: begin
                if (strobe && (lost || cur_last)) begin
                    state_nx = ACC_WAIT;
                end
            end
            default: state_nx = ACC_WAIT;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_bit    <= 1'b1;
            cur_last   <= 1'b0;
            tx_bit_ack <= 1'b0;
            collision  <= 1'b0;
            tx_done    <= 1'b0;
        end else begin
            tx_bit_ack <= 1'b0;
            collision  <= 1'b0;
            tx_done    <= 1'b0;
            unique case (state)
                ACC_WAIT: begin
                    if (start_tx) begin
                        cur_bit    <= tx_bit_in;
                        cur_last   <= tx_last;
                        tx_bit_ack <= 1'b1;
                    end
                end
                ACC_SEND: begin
                    if (strobe) begin
                        if (lost) begin
                            collision <= 1'b1;
                            cur_bit   <= 1'b1;
                        end else if (cur_last) begin
                            tx_done <= 1'b1;
                            cur_bit <= 1'b1;
                        end else begin
                            cur_bit    <= tx_bit_in;
                            cur_last   <= tx_last;
                            tx_bit_ack <= 1'b1;
                        end
                    end
                end
                default: begin
                    cur_bit <= 1'b1;
                end
            endcase
        end
    end

    assign d_out = (state == ACC_SEND) ? cur_bit : 1'b1;

endmodule

// File: rtl/dchan_access_arbiter.sv
module dchan_access_arbiter
    import dacc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_strobe,
    input  logic               echo_in,
    input  logic               tx_req,
    input  logic               tx_bit_in,
    input  logic               tx_last,
    input  logic [CLASS_W-1:0] prio_class,
    output logic               d_out,
    output logic               tx_bit_ack,
    output logic               access_granted,
    output logic               collision,
    output logic               tx_done,
    output logic [7:0]         monitor_status
);

    acc_state_e       state;
    logic             start_tx;
    logic             done_evt;
    logic             ready;
    logic             lowered;
    logic             cnt_clear;
    logic             restore_evt;
    logic [RUN_W-1:0] thr;
    logic [RUN_W-1:0] run_cnt;

    assign cnt_clear   = (state != ACC_WAIT) || start_tx;
    assign restore_evt = (state == ACC_WAIT) && bit_strobe && ready;

    dacc_run_counter #(
        .RUN_W (RUN_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (bit_strobe),
        .echo    (echo_in),
        .clear   (cnt_clear),
        .thr     (thr),
        .run_cnt (run_cnt),
        .ready   (ready)
    );

    dacc_prio_tracker #(
        .BASE_RUN    (BASE_RUN),
        .CLASS_STEP  (CLASS_STEP),
        .LOWER_STEP  (LOWER_STEP),
        .NUM_CLASSES (NUM_CLASSES),
        .CLASS_W     (CLASS_W),
        .RUN_W       (RUN_W)
    ) prio_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_class  (prio_class),
        .lower_evt   (done_evt),
        .restore_evt (restore_evt),
        .thr         (thr),
        .lowered     (lowered)
    );

    dacc_tx_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (bit_strobe),
        .echo       (echo_in),
        .tx_req     (tx_req),
        .tx_bit_in  (tx_bit_in),
        .tx_last    (tx_last),
        .ready      (ready),
        .state      (state),
        .start_tx   (start_tx),
        .done_evt   (done_evt),
        .d_out      (d_out),
        .tx_bit_ack (tx_bit_ack),
        .collision  (collision),
        .tx_done    (tx_done)
    );

    assign access_granted = (state == ACC_SEND);

    always_comb begin
        monitor_status                = '0;
        monitor_status[MON_GRANT_BIT] = (state == ACC_SEND);
        monitor_status[MON_READY_BIT] = ready;
        monitor_status[MON_LOWER_BIT] = lowered;
        monitor_status[MON_CLASS_BIT] = prio_class[0];
    end

endmodule

// File: rtl/dacc_checker.sv
module dacc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_strobe,
    input logic       echo_in,
    input logic       tx_req,
    input logic       tx_bit_in,
    input logic       tx_last,
    input logic [0:0] prio_class,
    input logic       d_out,
    input logic       tx_bit_ack,
    input logic       access_granted,
    input logic       collision,
    input logic       tx_done,
    input logic [7:0] monitor_status
);

    a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !access_granted |-> d_out);

    a_r3_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_granted) |-> ($past(tx_req) && $past(bit_strobe)));

    a_r5_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_ack |-> $past(bit_strobe));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_bit_ack, collision, tx_done}));

    a_r7_collision_releases: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (!access_granted && d_out && $past(access_granted) && $past(!echo_in)));

    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!access_granted && $past(access_granted) && $past(bit_strobe)));

    a_r7_state_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_strobe) |-> $stable(access_granted));

    a_r10_grant_bit: assert property (@(posedge clk) disable iff (!rst_n)
        monitor_status[5] == access_granted);

endmodule

bind dchan_access_arbiter dacc_checker chk_i (.*);

// File: tb/dchan_access_arbiter_tb_top.sv
`timescale 1ns/100ps
module dchan_access_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       echo_in = 1'b1;
    logic       tx_req = 1'b0;
    logic       tx_bit_in = 1'b0;
    logic       tx_last = 1'b0;
    logic [0:0] prio_class = 1'b0;
    logic       d_out;
    logic       tx_bit_ack;
    logic       access_granted;
    logic       collision;
    logic       tx_done;
    logic [7:0] monitor_status;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dchan_access_arbiter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_strobe     (bit_strobe),
        .echo_in        (echo_in),
        .tx_req         (tx_req),
        .tx_bit_in      (tx_bit_in),
        .tx_last        (tx_last),
        .prio_class     (prio_class),
        .d_out          (d_out),
        .tx_bit_ack     (tx_bit_ack),
        .access_granted (access_granted),
        .collision      (collision),
        .tx_done        (tx_done),
        .monitor_status (monitor_status)
    );

    // segment: {repeat[13:9], echo, req, bit, last, exp d_out, grant, ack, coll, done}
    localparam logic [13:0] SEG [11] = '{
        {5'd8, 4'b1100, 5'b10000},   // wait 8 ones, class 0 normal
        {5'd1, 4'b1100, 5'b01100},   // grant, first bit 0
        {5'd1, 4'b0110, 5'b11100},   // 0 echoed 0, next bit 1
        {5'd1, 4'b1111, 5'b11100},   // 1 echoed 1, last bit 1
        {5'd1, 4'b1100, 5'b10001},   // last confirmed -> done
        {5'd9, 4'b1111, 5'b10000},   // lowered: 9 ones, no grant
        {5'd1, 4'b1111, 5'b11100},   // grant after lowered run
        {5'd1, 4'b0111, 5'b10010},   // sent 1 saw 0 -> collision
        {5'd8, 4'b1111, 5'b10000},   // fresh run of 8 needed
        {5'd1, 4'b1111, 5'b11100},   // grant
        {5'd1, 4'b1111, 5'b10001}    // done
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic e, input logic r, input logic b, input logic l);
        @(negedge clk);
        echo_in    = e;
        tx_req     = r;
        tx_bit_in  = b;
        tx_last    = l;
        bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    function automatic logic [7:0] outs();
        return {3'b000, d_out, access_granted, tx_bit_ack, collision, tx_done};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        chk("R1 outputs in reset", outs(), 8'h10);
        do_reset();
        chk("R1 outputs after reset", outs(), 8'h10);
        chk("R1 R10 monitor after reset", monitor_status, 8'h00);

        // table: R3 R4 R5 R6 R7 R8 R9
        for (int s = 0; s < 11; s++) begin
            for (int k = 0; k < int'(SEG[s][13:9]); k++) begin
                strobe(SEG[s][8], SEG[s][7], SEG[s][6], SEG[s][5]);
                chk($sformatf("R3 R5 R6 R7 R8 seg%0d step%0d", s, k), outs(), {3'b000, SEG[s][4:0]});
            end
        end

        // R2 saturation with long idle line, R4 no request
        chk("R9 R10 lowered after done", monitor_status, 8'h08);
        for (int k = 0; k < 20; k++) begin
            strobe(1'b1, 1'b0, 1'b0, 1'b0);
            chk("R4 idle without request", outs(), 8'h10);
        end
        chk("R2 R9 R10 saturated ready, level restored", monitor_status, 8'h10);
        strobe(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R2 R3 grant after long idle", outs(), 8'h0C);
        chk("R10 monitor while granted", monitor_status, 8'h20);
        @(negedge clk);
        chk("R5 ack lasts one clock", {7'd0, tx_bit_ack}, 8'h00);
        strobe(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 sent 0 echoed 0 completes", outs(), 8'h11);

        // R1 reset during transmission
        for (int k = 0; k < 9; k++) strobe(1'b1, 1'b1, 1'b0, 1'b0);
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 lowered grant", outs(), 8'h0C);
        do_reset();
        chk("R1 reset releases line", outs(), 8'h10);
        chk("R1 reset clears level", monitor_status, 8'h00);

        // R2 echo zero restarts the run
        for (int k = 0; k < 7; k++) strobe(1'b1, 1'b1, 1'b1, 1'b0);
        strobe(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R2 zero inside run", outs(), 8'h10);
        for (int k = 0; k < 8; k++) begin
            strobe(1'b1, 1'b1, 1'b1, 1'b0);
            chk("R2 restarted run no grant", outs(), 8'h10);
        end
        strobe(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R3 grant after restarted run", outs(), 8'h1C);
        strobe(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R7 collision on first bit", outs(), 8'h12);
        chk("R7 level unchanged after collision", monitor_status, 8'h00);

        // class 1 thresholds 10 and 11
        do_reset();
        prio_class = 1'b1;
        for (int k = 0; k < 10; k++) begin
            strobe(1'b1, 1'b1, 1'b1, 1'b1);
            chk("R3 class1 below 10", outs(), 8'h10);
        end
        chk("R10 class1 ready", monitor_status, 8'h14);
        strobe(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R3 class1 grant", outs(), 8'h1C);
        chk("R10 class1 granted", monitor_status, 8'h24);
        strobe(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R8 class1 done", outs(), 8'h11);
        for (int k = 0; k < 11; k++) begin
            strobe(1'b1, 1'b1, 1'b1, 1'b1);
            chk("R3 R8 class1 lowered below 11", outs(), 8'h10);
        end
        chk("R9 R10 class1 lowered ready", monitor_status, 8'h1C);
        strobe(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R3 class1 lowered grant", outs(), 8'h1C);
        chk("R9 level restored", monitor_status, 8'h24);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule